// File: doc/BRIEF.md
# Bitstream Binarized Neuron

This block evaluates one binarized neuron on bipolar stochastic bitstreams. In bipolar encoding a logic-1 bit stands for +1 and a logic-0 bit for -1. Each beat carries one bit of every input stream and one bit of the matching weight stream, for all synapses at once. The block multiplies each input/weight pair with an XNOR gate. It then counts how many product bits in the beat are ones and feeds that count into a signed up/down accumulator. The accumulator rises by one for every product one and falls by one for every product zero.

The activation is the inverted sign bit of the accumulator. This masking is part of the counter, so no threshold subtractor follows the accumulation. A run starts with a start pulse and consumes exactly `LEN` accepted beats. The done flag then rises and stays high, with the activation frozen, until the next start.

Beats enter over a valid/ready handshake. `in_ready_o` is high only while a run is in progress. A beat counts only in a cycle where both `in_valid_i` and `in_ready_o` are high. The source may hold `in_valid_i` low at any time to pause the stream, and the block never drops a beat it has accepted. Outside a run, `in_ready_o` is low and the data lines are ignored.

Top module: `strm_neuron`

## Requirements
- R1: After reset, `done_o` is 0, `in_ready_o` is 0 and `act_o` is 1, because an empty count of zero resolves to +1.
- R2: `in_ready_o` is high only between an accepted start and the last beat of the run. Data offered while it is low, or beats with `in_valid_i` low, do not change the result.
- R3: The product of synapse j is 1 exactly when `in_x_i[j]` equals `in_w_i[j]`, which is a bitwise XNOR.
- R4: Each accepted beat changes the accumulator by (2*ones - NSYN), where ones is the number of synapses with a product of 1. Over a run the final count is 2*P - NSYN*LEN, where P is the total number of product ones.
- R5: At the end of a run, `act_o` is 1 when 2*P >= NSYN*LEN and 0 otherwise. An exact tie gives 1.
- R6: `done_o` rises in the cycle after the LEN-th accepted beat. In that same cycle `in_ready_o` drops to 0.
- R7: While `done_o` is high and no start arrives, `done_o` and `act_o` hold their values, whatever the stream inputs do.
- R8: A start pulse while a run is in progress is ignored. The run continues and produces the same result.
- R9: A start while not running clears `done_o`, restarts the accumulator at zero and raises `in_ready_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; begins a new run when not running |
| in_valid_i | input | 1 | Beat offered on the stream inputs |
| in_ready_o | output | 1 | Block accepts a beat this cycle |
| in_x_i | input | NSYN | One input-stream bit per synapse |
| in_w_i | input | NSYN | One weight-stream bit per synapse |
| done_o | output | 1 | Run finished; result valid and held |
| act_o | output | 1 | Activation: 1 means +1, 0 means -1 |

## Verification
The streams come in six patterns. In the first, every pair matches, so the count saturates upward and the activation must be +1. In the second, every pair differs, which checks the downward direction and the -1 result. A pattern with exactly half the pairs matching checks the tie rule. Two more patterns sit one product above and one product below the tie, and they separate a `>=` comparison from a `>` comparison and catch an off-by-one in the step size. A pseudo-random pattern with valid gaps is compared against a count of XNOR ones computed in the bench. It also checks that stalled cycles add nothing. Further runs offer beats before the start, pulse start in the middle of a run, and drive the inputs after done, to show that none of these moves the result.

// File: rtl/nrn_pkg.sv
package nrn_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } nrn_state_e;
endpackage

// File: rtl/nrn_xnor_pop.sv
module nrn_xnor_pop #(
  parameter int NSYN = 4,
  localparam int PW = $clog2(NSYN + 1)
) (
  input  logic [NSYN-1:0] x_i,
  input  logic [NSYN-1:0] w_i,
  output logic [PW-1:0]   ones_o
);
  logic [NSYN-1:0] prod;

  for (genvar j = 0; j < NSYN; j++) begin : g_mul
    assign prod[j] = ~(x_i[j] ^ w_i[j]);
  end

  always_comb begin
    ones_o = '0;
    for (int j = 0; j < NSYN; j++) begin
      ones_o = ones_o + PW'(prod[j]);
    end
  end
endmodule

// File: rtl/nrn_acc.sv
module nrn_acc #(
  parameter int NSYN = 4,
  parameter int LEN  = 512,
  localparam int PW = $clog2(NSYN + 1),
  localparam int CW = $clog2(NSYN * LEN + 1) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [PW-1:0] ones_i,
  output logic          pos_o
);
  logic signed [CW-1:0] count_q;
  logic signed [CW-1:0] delta;

  always_comb begin
    delta = signed'(CW'(ones_i)) + signed'(CW'(ones_i)) - signed'(CW'(NSYN));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (step_i) begin
      count_q <= count_q + delta;
    end
  end

  // sign mask: non-negative count (tie included) reads as +1
  assign pos_o = ~count_q[CW-1];
endmodule

// File: rtl/nrn_seq.sv
module nrn_seq
  import nrn_pkg::*;
#(
  parameter int LEN = 512,
  localparam int BW = $clog2(LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic beat_i,
  output logic run_o,
  output logic clear_o,
  output logic done_o
);
  nrn_state_e    state_q;
  logic [BW-1:0] beat_q;
  logic          last_beat;

  assign run_o     = (state_q == ST_RUN);
  assign done_o    = (state_q == ST_DONE);
  assign clear_o   = start_i && !run_o;
  assign last_beat = beat_i && (beat_q == BW'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            beat_q  <= '0;
          end
        end
        ST_RUN: begin
          if (last_beat) begin
            state_q <= ST_DONE;
          end
          if (beat_i) begin
            beat_q <= beat_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strm_neuron.sv
module strm_neuron #(
  parameter int NSYN = 4,
  parameter int LEN  = 512
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [NSYN-1:0] in_x_i,
  input  logic [NSYN-1:0] in_w_i,
  output logic            done_o,
  output logic            act_o
);
  localparam int PW = $clog2(NSYN + 1);

  logic          run;
  logic          clear;
  logic          beat;
  logic [PW-1:0] ones;

  assign in_ready_o = run;
  assign beat       = in_valid_i && run;

  nrn_seq #(.LEN(LEN)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .beat_i  (beat),
    .run_o   (run),
    .clear_o (clear),
    .done_o  (done_o)
  );

  nrn_xnor_pop #(.NSYN(NSYN)) u_pop (
    .x_i    (in_x_i),
    .w_i    (in_w_i),
    .ones_o (ones)
  );

  nrn_acc #(.NSYN(NSYN), .LEN(LEN)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .step_i  (beat),
    .ones_i  (ones),
    .pos_o   (act_o)
  );
endmodule

// File: rtl/nrn_chk.sv
module nrn_chk #(
  parameter int LEN = 512,
  localparam int BW = $clog2(LEN + 1)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic done_o,
  input logic act_o
);
  logic [BW-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (start_i && !in_ready_o) seen_q <= '0;
    else if (in_valid_i && in_ready_o) seen_q <= seen_q + 1'b1;
  end

  a_r2_ready_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && done_o));

  a_r6_done_after_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (seen_q == BW'(LEN)));

  a_r6_last_beat_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && seen_q == BW'(LEN - 1)) |=> (done_o && !in_ready_o));

  a_r7_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(act_o)));

  a_r8_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && start_i && !in_valid_i) |=> in_ready_o);

  a_r9_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !in_ready_o) |=> (in_ready_o && !done_o && act_o));
endmodule

bind strm_neuron nrn_chk #(.LEN(LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .done_o     (done_o),
  .act_o      (act_o)
);

// File: tb/sim_strm_neuron.sv
module sim_strm_neuron;
  localparam int NSYN = 4;
  localparam int LEN  = 512;
  localparam time TCLK = 10ns;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic            in_valid_i = 1'b0;
  logic            in_ready_o;
  logic [NSYN-1:0] in_x_i = '0;
  logic [NSYN-1:0] in_w_i = '0;
  logic            done_o;
  logic            act_o;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  logic [31:0] rng = 32'h1234_5678;

  strm_neuron #(.NSYN(NSYN), .LEN(LEN)) u0 (.*);

  always #(TCLK / 2) clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_errors = n_errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] step_rng(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic pulse_start();
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // mode: 0 all match, 1 none, 2 tie, 3 tie-1, 4 tie+1, 5 random
  task automatic run_case(input int mode, input bit gaps, input bit mid_start,
                          input string name);
    int p = 0;
    int exp_act;
    logic [NSYN-1:0] m;
    pulse_start();
    check(in_ready_o === 1'b1 && done_o === 1'b0, {"R9 start ", name}, int'(in_ready_o), 1);
    check(act_o === 1'b1, {"R9 cleared count ", name}, int'(act_o), 1);
    for (int b = 0; b < LEN; b++) begin
      rng = step_rng(rng);
      if (gaps && rng[5:4] == 2'b00) begin
        in_valid_i = 1'b0;
        in_x_i = rng[11:8];
        in_w_i = rng[15:12];
        @(negedge clk_i);
      end
      rng = step_rng(rng);
      case (mode)
        0: m = '1;
        1: m = '0;
        2: m = 4'b0011;
        3: m = (b == 0) ? 4'b0010 : 4'b0011;
        4: m = (b == 0) ? 4'b0111 : 4'b0011;
        default: m = rng[3:0];
      endcase
      for (int j = 0; j < NSYN; j++) p += int'(m[j]);
      in_x_i = rng[11:8];
      in_w_i = rng[11:8] ^ ~m;          // R3: equal bits give product 1
      in_valid_i = 1'b1;
      start_i = mid_start && (b == LEN / 2);
      if (b == LEN - 1)
        check(done_o === 1'b0, {"R6 done early ", name}, int'(done_o), 0);
      @(negedge clk_i);
      start_i = 1'b0;
    end
    in_valid_i = 1'b0;
    exp_act = (2 * p >= NSYN * LEN) ? 1 : 0;
    check(done_o === 1'b1 && in_ready_o === 1'b0, {"R6 done timing ", name}, int'(done_o), 1);
    check(act_o === exp_act[0], {"R4 R5 activation ", name}, int'(act_o), exp_act);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(done_o === 1'b0, "R1 done after reset", int'(done_o), 0);
    check(in_ready_o === 1'b0, "R1 ready after reset", int'(in_ready_o), 0);
    check(act_o === 1'b1, "R1 act after reset", int'(act_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_idle_ignored();
    // R2: beats offered while idle must not count
    in_valid_i = 1'b1;
    in_x_i = 4'b1111;
    in_w_i = 4'b0000;
    repeat (20) begin
      @(negedge clk_i);
      check(in_ready_o === 1'b0, "R2 ready while idle", int'(in_ready_o), 0);
    end
    in_valid_i = 1'b0;
    run_case(2, 1'b0, 1'b0, "tie after idle beats");
  endtask

  task automatic t_hold();
    logic a0;
    a0 = act_o;
    for (int k = 0; k < 8; k++) begin
      rng = step_rng(rng);
      in_valid_i = rng[0];
      in_x_i = rng[7:4];
      in_w_i = rng[11:8];
      @(negedge clk_i);
      check(done_o === 1'b1 && act_o === a0, "R7 result held", int'(act_o), int'(a0));
    end
    in_valid_i = 1'b0;
  endtask

  initial begin
    t_reset();
    run_case(0, 1'b0, 1'b0, "all match");
    t_hold();
    run_case(1, 1'b0, 1'b0, "all differ");
    t_hold();
    run_case(2, 1'b0, 1'b0, "exact tie");
    run_case(3, 1'b0, 1'b0, "below tie");
    run_case(4, 1'b0, 1'b0, "above tie");
    run_case(5, 1'b1, 1'b0, "random gaps R2");
    run_case(3, 1'b1, 1'b1, "mid start R8 below");
    run_case(4, 1'b0, 1'b1, "mid start R8 above");
    t_idle_ignored();
    run_case(5, 1'b0, 1'b0, "random");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule